// File: doc/BRIEF.md
# Quad-SPI Flash Erase Command Decoder

This block sits on the device side of a four-bit serial flash interface. While chip-select is low it collects one nibble from the data bus on each rising edge of the serial clock and packs the nibbles into bytes, high nibble first. When chip-select returns high it checks the collected frame. A correct frame starts a self-timed erase, sets up the write-enable latch, or does nothing. Nothing in the frame takes effect before chip-select rises.

Three frames are recognised:
- A write-enable byte, 06h, sets the latch.
- A block-erase byte, D8h, followed by a three-byte address.
- A chip-erase byte, C7h, on its own.

The block size depends on where the address falls. The first 32 KB of the device is split into 8 KB blocks. The next 32 KB is one 32 KB block. Everything above 64 KB is in 64 KB blocks.

A protection input holds one bit per 64 KB sector. It can veto a block erase. It vetoes a chip erase if any bit is set. When an erase starts, the block emits a one-cycle start pulse with the block base and a size code. It then holds busy for a parameterised number of cycles, which differs between block and chip erase.

Top module: `qspi_erase_decoder`

## Requirements
- R1: While csN is low, each rising edge of sck captures sio as the next nibble. Two nibbles form a byte, most significant nibble first. The first byte of a frame is the opcode, and any following bytes are the address, highest byte first.
- R2: A frame of exactly two nibbles carrying 06h sets wel once csN rises.
- R3: A frame of exactly eight nibbles with opcode D8h and wel set starts a block erase when csN rises. On the next clock edge, eraseStart pulses for one cycle, busy goes high, and eraseBase and eraseSize present the target block.
- R4: The size code is 0 for 8 KB, 1 for 32 KB, 2 for 64 KB and 3 for chip. An address below 8000h selects an 8 KB block, with address bits 12..0 cleared in the base. An address from 8000h up to FFFFh selects the 32 KB block at 8000h, so bits 14..13 are ignored. Any higher address selects a 64 KB block, with bits 15..0 cleared in the base.
- R5: A block erase whose 64 KB sector, given by address bits above 15, has its protect bit set is dropped. No pulse is issued, busy stays low and wel is unchanged.
- R6: A two-nibble C7h frame with wel set starts a chip erase, with base 0 and size code 3. The frame is dropped if any protect bit is set.
- R7: An erase frame received while wel is clear is dropped.
- R8: wel clears on the clock edge at which an erase is accepted.
- R9: A csN rise after any other nibble count, or after an unknown opcode, has no effect.
- R10: busy stays high for exactly BLOCK_CYC cycles after a block erase starts, and for exactly CHIP_CYC cycles after a chip erase starts.
- R11: Every frame that completes while busy is high is ignored, including write-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select; its rising edge ends a frame |
| sck | input | 1 | Serial clock, sampled; a rising edge captures a nibble |
| sio | input | 4 | Serial data nibble |
| protect | input | NUM_SECT | One protect bit per 64 KB sector |
| busy | output | 1 | High while an erase is in progress |
| wel | output | 1 | Write-enable latch |
| eraseStart | output | 1 | One-cycle pulse when an erase begins |
| eraseBase | output | ADDR_W | Byte address of the erased region |
| eraseSize | output | 2 | Size code of the erased region |

## Verification
The bench aims at region boundaries in the size map:
- An address just inside the 32 KB block with bits 14..13 set. A decoder that does not mask these bits reports an unaligned base.
- A 64 KB address with bits 15..13 set. A wrong mask here also shows up as a bad base.

It drives truncated and overlong frames, frames without write-enable, and frames sent during busy. A design that acts on a partial frame, or forgets the busy gate, produces an erase pulse the scoreboard did not expect. Protected-sector and chip-erase vetoes are checked through wel staying set. The busy length is counted per erase, so an off-by-one in the timer is reported.

// File: rtl/qspi_erase_pkg.sv
package qspi_erase_pkg;
  typedef enum logic [1:0] {
    SZ_8K   = 2'd0,
    SZ_32K  = 2'd1,
    SZ_64K  = 2'd2,
    SZ_CHIP = 2'd3
  } eraseSize_t;

  typedef struct packed {
    logic shift;  // capture sio as next nibble
    logic clear;  // drop frame state while deselected
  } dpStrobe_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_BLOCK = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;
  localparam int SHORT_NIBS = 2;
  localparam int LONG_NIBS  = 8;
endpackage

// File: rtl/qspi_erase_dp.sv
module qspi_erase_dp
  import qspi_erase_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int NUM_SECT = 1 << (ADDR_W - 16)
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [3:0]          sio,
  input  logic [NUM_SECT-1:0] protect,
  output logic [3:0]          nibCnt,
  output logic [7:0]          opShort,
  output logic [7:0]          opLong,
  output logic [ADDR_W-1:0]   blkBase,
  output eraseSize_t          blkSize,
  output logic                blkProt
);
  localparam int SHIFT_W = 4 * LONG_NIBS;
  localparam int SECT_W  = ADDR_W - 16;

  logic [SHIFT_W-1:0] shiftReg;
  logic [ADDR_W-1:0]  addr;
  logic [SECT_W-1:0]  sector;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      nibCnt   <= '0;
    end else if (strobe.clear) begin
      nibCnt <= '0;
    end else if (strobe.shift) begin
      shiftReg <= {shiftReg[SHIFT_W-5:0], sio};
      if (nibCnt != 4'hF) nibCnt <= nibCnt + 4'd1;
    end
  end

  assign opShort = shiftReg[7:0];
  assign opLong  = shiftReg[SHIFT_W-1 -: 8];
  assign addr    = shiftReg[ADDR_W-1:0];
  assign sector  = addr[ADDR_W-1:16];
  assign blkProt = protect[sector];

  always_comb begin
    if (sector != '0) begin
      blkSize = SZ_64K;
      blkBase = {addr[ADDR_W-1:16], 16'h0000};
    end else if (addr[15]) begin
      blkSize = SZ_32K;
      blkBase = {addr[ADDR_W-1:15], 15'h0000};
    end else begin
      blkSize = SZ_8K;
      blkBase = {addr[ADDR_W-1:13], 13'h0000};
    end
  end

  a_r1_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clear) |-> nibCnt == 4'd0);
  a_r4_base_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (blkSize == SZ_64K) |-> blkBase[15:0] == 16'h0000);
endmodule

// File: rtl/qspi_erase_ctrl.sv
module qspi_erase_ctrl
  import qspi_erase_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int BLOCK_CYC = 40,
  parameter int CHIP_CYC  = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              anyProt,
  input  logic [3:0]        nibCnt,
  input  logic [7:0]        opShort,
  input  logic [7:0]        opLong,
  input  logic [ADDR_W-1:0] blkBase,
  input  eraseSize_t        blkSize,
  input  logic              blkProt,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              wel,
  output logic              eraseStart,
  output logic [ADDR_W-1:0] eraseBase,
  output eraseSize_t        eraseSize
);
  localparam int MAX_CYC = (BLOCK_CYC > CHIP_CYC) ? BLOCK_CYC : CHIP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic sckPrev, csPrev, sckRise, csRise;
  logic wrenOk, chipOk, blockOk;
  logic [CNT_W-1:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
    end
  end

  assign sckRise      = sck & ~sckPrev & ~csN;
  assign csRise       = csN & ~csPrev;
  assign strobe.shift = sckRise;
  assign strobe.clear = csN;

  assign wrenOk  = csRise && !busy && nibCnt == 4'(SHORT_NIBS) && opShort == OP_WREN;
  assign chipOk  = csRise && !busy && wel && !anyProt &&
                   nibCnt == 4'(SHORT_NIBS) && opShort == OP_CHIP;
  assign blockOk = csRise && !busy && wel && !blkProt &&
                   nibCnt == 4'(LONG_NIBS) && opLong == OP_BLOCK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel        <= 1'b0;
      eraseStart <= 1'b0;
      eraseBase  <= '0;
      eraseSize  <= SZ_8K;
      busyCnt    <= '0;
    end else begin
      eraseStart <= chipOk | blockOk;
      if (chipOk) begin
        eraseBase <= '0;
        eraseSize <= SZ_CHIP;
        busyCnt   <= CNT_W'(CHIP_CYC);
      end else if (blockOk) begin
        eraseBase <= blkBase;
        eraseSize <= blkSize;
        busyCnt   <= CNT_W'(BLOCK_CYC);
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (chipOk | blockOk) wel <= 1'b0;
      else if (wrenOk)      wel <= 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

  a_r3_start_after_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> $past(csN) && !$past(csPrev));
  a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> !wel);
  a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> !$past(busy));
  a_r10_busy_with_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> eraseStart);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);
endmodule

// File: rtl/qspi_erase_decoder.sv
module qspi_erase_decoder
  import qspi_erase_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int NUM_SECT  = 1 << (ADDR_W - 16),
  parameter int BLOCK_CYC = 40,
  parameter int CHIP_CYC  = 100
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sck,
  input  logic [3:0]          sio,
  input  logic [NUM_SECT-1:0] protect,
  output logic                busy,
  output logic                wel,
  output logic                eraseStart,
  output logic [ADDR_W-1:0]   eraseBase,
  output logic [1:0]          eraseSize
);
  dpStrobe_t         strobe;
  logic [3:0]        nibCnt;
  logic [7:0]        opShort, opLong;
  logic [ADDR_W-1:0] blkBase;
  eraseSize_t        blkSize, sizeOut;
  logic              blkProt;

  qspi_erase_dp #(.ADDR_W(ADDR_W), .NUM_SECT(NUM_SECT)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sio(sio), .protect(protect),
    .nibCnt(nibCnt), .opShort(opShort), .opLong(opLong),
    .blkBase(blkBase), .blkSize(blkSize), .blkProt(blkProt)
  );

  qspi_erase_ctrl #(.ADDR_W(ADDR_W), .BLOCK_CYC(BLOCK_CYC), .CHIP_CYC(CHIP_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .anyProt(|protect),
    .nibCnt(nibCnt), .opShort(opShort), .opLong(opLong),
    .blkBase(blkBase), .blkSize(blkSize), .blkProt(blkProt),
    .strobe(strobe), .busy(busy), .wel(wel), .eraseStart(eraseStart),
    .eraseBase(eraseBase), .eraseSize(sizeOut)
  );

  assign eraseSize = sizeOut;
endmodule

// File: tb/tb_qspi_erase_decoder.sv
module tb_qspi_erase_decoder;
  localparam int ADDR_W = 22;
  localparam int NUM_SECT = 1 << (ADDR_W - 16);
  localparam int BLOCK_CYC = 40;
  localparam int CHIP_CYC = 100;

  typedef struct packed {
    logic [31:0] base;
    logic [1:0]  size;
    logic [31:0] dur;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic [3:0] sio = '0;
  logic [NUM_SECT-1:0] protect = '0;
  logic busy, wel, eraseStart;
  logic [ADDR_W-1:0] eraseBase;
  logic [1:0] eraseSize;

  int testsRun = 0;
  int testsFailed = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  qspi_erase_decoder #(.ADDR_W(ADDR_W), .BLOCK_CYC(BLOCK_CYC), .CHIP_CYC(CHIP_CYC)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .sio(sio), .protect(protect),
    .busy(busy), .wel(wel), .eraseStart(eraseStart),
    .eraseBase(eraseBase), .eraseSize(eraseSize)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 1; i >= 0; i--) begin
      @(negedge clk); sck = 1'b0; sio = b[4*i +: 4];
      @(negedge clk); sck = 1'b1;
    end
  endtask

  task automatic sendNib(input logic [3:0] n);
    @(negedge clk); sck = 1'b0; sio = n;
    @(negedge clk); sck = 1'b1;
  endtask

  task automatic beginFrame();
    @(negedge clk); csN = 1'b0; sck = 1'b0;
  endtask

  task automatic endFrame();
    @(negedge clk); sck = 1'b0;
    @(negedge clk); csN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmdWren();
    beginFrame(); sendByte(8'h06); endFrame();
  endtask

  task automatic cmdBlock(input logic [23:0] a);
    beginFrame(); sendByte(8'hD8);
    sendByte(a[23:16]); sendByte(a[15:8]); sendByte(a[7:0]);
    endFrame();
  endtask

  task automatic cmdChip();
    beginFrame(); sendByte(8'hC7); endFrame();
  endtask

  task automatic expectErase(input logic [31:0] base, input logic [1:0] size, input int dur);
    expItem_t it;
    it.base = base; it.size = size; it.dur = dur;
    expQ.push_back(it);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: pop on each start pulse, then count the busy window
  initial begin
    expItem_t cur;
    bit active = 0;
    int n = 0;
    forever begin
      @(negedge clk);
      if (rstN && eraseStart) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R5/R7/R9/R11 unexpected erase", {30'b0, eraseSize}, 32'h0);
        end else begin
          cur = expQ.pop_front();
          check(eraseBase == cur.base[ADDR_W-1:0], "R4 eraseBase", 32'(eraseBase), cur.base);
          check(eraseSize == cur.size, "R4 eraseSize", 32'(eraseSize), 32'(cur.size));
          active = 1; n = 0;
        end
      end
      if (active) begin
        if (busy) n++;
        else begin
          check(n == int'(cur.dur), "R10 busy length", 32'(n), cur.dur);
          active = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && wel == 0 && eraseStart == 0, "reset state", {busy, wel, eraseStart}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R7: erase without write-enable
    cmdBlock(24'h004000);
    check(busy == 0, "R7 block without wel", 32'(busy), 32'h0);

    // R2, R1
    cmdWren();
    check(wel == 1, "R2 wren sets wel", 32'(wel), 32'h1);

    // R3 R4 8K region
    expectErase(32'h004000, 2'd0, BLOCK_CYC);
    cmdBlock(24'h005A31);
    check(busy == 1, "R3 busy after block", 32'(busy), 32'h1);
    check(wel == 0, "R8 wel cleared", 32'(wel), 32'h0);
    // R11 wren during busy ignored
    cmdWren();
    check(wel == 0, "R11 wren while busy", 32'(wel), 32'h0);
    waitIdle();

    // R4 32K region, bits 14:13 set
    cmdWren();
    expectErase(32'h008000, 2'd1, BLOCK_CYC);
    cmdBlock(24'h00EBCD);
    waitIdle();

    // R4 64K region, bits 15:13 set
    cmdWren();
    expectErase(32'h120000, 2'd2, BLOCK_CYC);
    cmdBlock(24'h12F123);
    waitIdle();

    // R5 protected sector
    protect = '0; protect[6'h12] = 1'b1;
    cmdWren();
    cmdBlock(24'h123456);
    check(busy == 0, "R5 protected block busy", 32'(busy), 32'h0);
    check(wel == 1, "R5 wel kept", 32'(wel), 32'h1);

    // R6 chip vetoed by any protection
    protect = '0; protect[NUM_SECT-1] = 1'b1;
    cmdChip();
    check(busy == 0 && wel == 1, "R6 chip protected", {busy, wel}, 32'h1);

    // R9 truncated block frame
    protect = '0;
    beginFrame(); sendByte(8'hD8); sendByte(8'h01); sendByte(8'h00); endFrame();
    check(busy == 0 && wel == 1, "R9 truncated frame", {busy, wel}, 32'h1);
    // R9 overlong chip frame
    beginFrame(); sendByte(8'hC7); sendNib(4'h0); endFrame();
    check(busy == 0 && wel == 1, "R9 overlong frame", {busy, wel}, 32'h1);
    // R9 unknown opcode
    beginFrame(); sendByte(8'h20); endFrame();
    check(busy == 0 && wel == 1, "R9 unknown opcode", {busy, wel}, 32'h1);

    // R6 chip erase accepted
    expectErase(32'h0, 2'd3, CHIP_CYC);
    cmdChip();
    check(busy == 1 && wel == 0, "R6 chip accepted", {busy, wel}, 32'h2);
    // R11 block during busy with wel cleared path: set nothing, still ignored
    cmdBlock(24'h200000);
    waitIdle();

    check(expQ.size() == 0, "R3 all expected erases seen", 32'(expQ.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule